// File: doc/BRIEF.md
# Table-Driven AES Round Column Engine

This block produces one 32-bit column of an AES-128 middle round in a single registered step. It reads the four state bytes that lie on the shifted diagonal for the requested column. Each byte goes through its own lookup table, which folds byte substitution and the column mixing into one 32-bit word. The four words are combined with XOR, and the round-key word is XORed in last.

A caller supplies the whole 128-bit state, a 2-bit column number and the matching key word, and raises `in_valid`. One clock later the finished column appears on `col_o` with `out_valid` high. Issuing the four column numbers on consecutive cycles with the same state yields a complete middle round. The tables are built from functions that compute the substitution from field inversion and the affine map, so no constant lists are stored in the source.

Top module: `aes_tcol_round`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `col_o` is 0.
- R2: `out_valid` is high in exactly the cycle after a rising clock edge that sampled `in_valid` high, and low after any edge that sampled it low.
- R3: The result for column j is formed from state bytes a[r][(j+r) mod 4] for rows r = 0..3, so row r is taken shifted left by r.
- R4: State byte k (k = 0..15) sits at bits [127-8k -: 8], and a[r][c] is byte 4c+r. In `col_o` and `rkey_i`, row 0 is bits [31:24] and row 3 is bits [7:0].
- R5: For substituted bytes s0..s3, the output rows are 2s0^3s1^s2^s3, s0^2s1^3s2^s3, s0^s1^2s2^3s3 and 3s0^s1^s2^2s3, with products in GF(2^8) modulo 0x11B.
- R6: Substitution is the field inverse (0 maps to 0) followed by the affine map, so an all-zero state with a zero key gives 0x63636363.
- R7: `col_o` equals the mixed column XOR `rkey_i`. An all-zero state with key 0xFFFFFFFF gives 0x9C9C9C9C.
- R8: When `in_valid` is low, `col_o` keeps its last value, whatever `state_i`, `col_i` and `rkey_i` carry.
- R9: A new request is accepted on every cycle, and results come out in request order with no gap.
- R10: Round-1 input 00102030405060708090a0b0c0d0e0f0 with key words d6aa74fd, d2af72fa, daa678f1, d6ab76fe gives the columns of 89d810e8855ace682d1843d8cb128fe4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for this cycle |
| state_i | input | 128 | Round input state, byte 0 in the top bits |
| col_i | input | 2 | Output column number |
| rkey_i | input | 32 | Round-key word for that column |
| out_valid | output | 1 | Result strobe |
| col_o | output | 32 | Resulting column, row 0 in the top byte |

## Verification
The checker assumes that `state_i`, `col_i` and `rkey_i` hold known values in any cycle where `in_valid` is high. It uses the values sampled one edge earlier to rebuild the expected column by applying substitution and column mixing separately. The bench only changes inputs away from the clock edge. It fills the data inputs with unrelated patterns in idle cycles, so the hold rule sees noisy inputs, while every valid request carries fully defined data.

// File: rtl/aes_tcol_pkg.sv
package aes_tcol_pkg;
    localparam int BYTE_W  = 8;
    localparam int ROWS    = 4;
    localparam int WORD_W  = BYTE_W * ROWS;
    localparam int STATE_W = WORD_W * ROWS;
    localparam int NBYTES  = ROWS * ROWS;
    localparam int COL_W   = $clog2(ROWS);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // doubling in GF(2^8) with reduction 0x11B
    function automatic byte_t gf_dbl(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t x   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_dbl(x);
        end
        return acc;
    endfunction

    // a^254 by square and multiply; zero stays zero
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p = a;
        byte_t r = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t v, input int n);
        logic [2*BYTE_W-1:0] vv;
        vv = {v, v} << n;
        return vv[2*BYTE_W-1:BYTE_W];
    endfunction

    function automatic byte_t sbox_f(input byte_t a);
        byte_t v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // table word for a byte arriving from row `row`
    function automatic word_t ttab_f(input int row, input byte_t x);
        byte_t s;
        word_t w;
        logic [2*WORD_W-1:0] ww;
        s  = sbox_f(x);
        w  = {gf_dbl(s), s, s, gf_dbl(s) ^ s};
        ww = {w, w} >> (BYTE_W * row);
        return ww[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/tcol_diag_sel.sv
module tcol_diag_sel
    import aes_tcol_pkg::*;
(
    input  logic [STATE_W-1:0]            state_i,
    input  logic [COL_W-1:0]              col_i,
    output logic [ROWS-1:0][BYTE_W-1:0]   bytes_o
);
    logic [NBYTES-1:0][BYTE_W-1:0] st;
    assign st = state_i;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COL_W-1:0]   src_col;
        logic [2*COL_W-1:0] idx;
        assign src_col = col_i + COL_W'(r);
        assign idx     = {src_col, COL_W'(r)};
        // byte k lives at packed element NBYTES-1-k
        assign bytes_o[ROWS-1-r] = st[(2*COL_W)'(NBYTES-1) - idx];
    end
endmodule

// File: rtl/tcol_tbox.sv
module tcol_tbox
    import aes_tcol_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb word_o = ttab_f(ROW, byte_i);
endmodule

// File: rtl/tcol_fold.sv
module tcol_fold
    import aes_tcol_pkg::*;
#(
    parameter int N_IN = ROWS
) (
    input  logic [N_IN-1:0][WORD_W-1:0] words_i,
    input  logic [WORD_W-1:0]           key_i,
    output logic [WORD_W-1:0]           word_o
);
    always_comb begin
        word_o = key_i;
        for (int i = 0; i < N_IN; i++) word_o = word_o ^ words_i[i];
    end
endmodule

// File: rtl/aes_tcol_round.sv
module aes_tcol_round
    import aes_tcol_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [STATE_W-1:0] state_i,
    input  logic [COL_W-1:0]   col_i,
    input  logic [WORD_W-1:0]  rkey_i,
    output logic               out_valid,
    output logic [WORD_W-1:0]  col_o
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] col;
    } out_reg_t;

    logic [ROWS-1:0][BYTE_W-1:0] diag_w;
    logic [ROWS-1:0][WORD_W-1:0] tword_w;
    logic [WORD_W-1:0]           fold_w;
    out_reg_t                    out_d, out_q;

    tcol_diag_sel u_sel (
        .state_i (state_i),
        .col_i   (col_i),
        .bytes_o (diag_w)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_tbox
        tcol_tbox #(.ROW(r)) u_tbox (
            .byte_i (diag_w[ROWS-1-r]),
            .word_o (tword_w[r])
        );
    end

    tcol_fold #(.N_IN(ROWS)) u_fold (
        .words_i (tword_w),
        .key_i   (rkey_i),
        .word_o  (fold_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) out_d.col = fold_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign col_o     = out_q.col;
endmodule

// File: rtl/tcol_chk.sv
module tcol_chk
    import aes_tcol_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [STATE_W-1:0] state_i,
    input logic [COL_W-1:0]   col_i,
    input logic [WORD_W-1:0]  rkey_i,
    input logic               out_valid,
    input logic [WORD_W-1:0]  col_o
);
    // textbook path: substitute, then mix column by matrix
    function automatic word_t ref_col(input logic [STATE_W-1:0] st, input logic [COL_W-1:0] j,
                                      input word_t key);
        byte_t s [ROWS];
        logic [STATE_W-1:0] sh;
        for (int r = 0; r < ROWS; r++) begin
            sh   = st >> (BYTE_W * (NBYTES - 1 - (4 * ((int'(j) + r) % 4) + r)));
            s[r] = sbox_f(sh[BYTE_W-1:0]);
        end
        return key ^ {gf_mul(8'h02, s[0]) ^ gf_mul(8'h03, s[1]) ^ s[2] ^ s[3],
                      s[0] ^ gf_mul(8'h02, s[1]) ^ gf_mul(8'h03, s[2]) ^ s[3],
                      s[0] ^ s[1] ^ gf_mul(8'h02, s[2]) ^ gf_mul(8'h03, s[3]),
                      gf_mul(8'h03, s[0]) ^ s[1] ^ s[2] ^ gf_mul(8'h02, s[3])};
    endfunction

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(col_o));
    // R5
    col_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> col_o == ref_col($past(state_i), $past(col_i), $past(rkey_i)));
    // R3
    col_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(col_i));
endmodule

bind aes_tcol_round tcol_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .state_i   (state_i),
    .col_i     (col_i),
    .rkey_i    (rkey_i),
    .out_valid (out_valid),
    .col_o     (col_o)
);

// File: tb/aes_tcol_round_tb_top.sv
module aes_tcol_round_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] state_i = '0;
    logic [1:0]   col_i = '0;
    logic [31:0]  rkey_i = '0;
    logic         out_valid;
    logic [31:0]  col_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        prev_v = 1'b0;
    logic [31:0] last_col = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    aes_tcol_round dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .state_i(state_i),
        .col_i(col_i), .rkey_i(rkey_i), .out_valid(out_valid), .col_o(col_o)
    );

    // independent model
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        int acc = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x << 1;
            if (x > 255) x = x ^ 'h11B;
        end
        return acc[7:0];
    endfunction

    function automatic logic [7:0] m_sub(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] y;
        for (int c = 1; c < 256; c++)
            if (m_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
        for (int i = 0; i < 8; i++)
            y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return y ^ 8'h63;
    endfunction

    function automatic logic [31:0] m_col(input logic [127:0] st, input int j, input logic [31:0] k);
        logic [7:0] b [4];
        logic [7:0] d [4];
        logic [7:0] mat [4][4] = '{'{2,3,1,1}, '{1,2,3,1}, '{1,1,2,3}, '{3,1,1,2}};
        for (int r = 0; r < 4; r++) b[r] = m_sub(st[127 - 8*(4*((j+r)%4) + r) -: 8]);
        for (int r = 0; r < 4; r++) begin
            d[r] = 8'h00;
            for (int c = 0; c < 4; c++) d[r] = d[r] ^ m_mul(mat[r][c], b[c]);
        end
        return {d[0], d[1], d[2], d[3]} ^ k;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [127:0] st, input int j, input logic [31:0] k,
                        input logic [31:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1; state_i = st; col_i = 2'(j); rkey_i = k;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            in_valid = 1'b0; state_i = {4{lfsr}}; col_i = lfsr[1:0]; rkey_i = ~lfsr;
        end
    endtask

    always @(posedge clk) prev_v <= in_valid;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_valid == prev_v, "R2 valid timing", {31'd0, out_valid}, {31'd0, prev_v});
            if (out_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R9 unexpected result", col_o, 32'h0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(col_o === e, t, col_o, e);
                end
                last_col = col_o;
            end else begin
                check(col_o === last_col, "R8 hold", col_o, last_col);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        logic [127:0] tv_in = 128'h00102030405060708090a0b0c0d0e0f0;
        logic [127:0] tv_k  = 128'hd6aa74fdd2af72fadaa678f1d6ab76fe;
        logic [127:0] tv_o  = 128'h89d810e8855ace682d1843d8cb128fe4;
        logic [127:0] idx_st;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset valid", {31'd0, out_valid}, 32'h0);
        check(col_o === 32'h0, "R1 reset col", col_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && col_o === 32'h0, "R1 after release", col_o, 32'h0);

        // R6 zero state, R7 key inversion
        send('0, 0, 32'h0, 32'h63636363, "R6 zero state");
        send('0, 2, 32'hFFFFFFFF, 32'h9C9C9C9C, "R7 key xor");
        idle(2);

        // R10 known round, back to back (R9)
        for (int j = 0; j < 4; j++)
            send(tv_in, j, tv_k[127-32*j -: 32], tv_o[127-32*j -: 32], "R10 round vector");
        for (int j = 0; j < 4; j++)
            send(tv_in, j, tv_k[127-32*j -: 32], m_col(tv_in, j, tv_k[127-32*j -: 32]), "R9 model agrees");
        idle(3);

        // R3 / R4 distinct byte per position
        for (int k = 0; k < 16; k++) idx_st[127-8*k -: 8] = 8'(k * 17 + 1);
        for (int j = 3; j >= 0; j--) send(idx_st, j, 32'h0, m_col(idx_st, j, 32'h0), "R3 R4 diagonal");
        idle(2);

        // R5 varied data with gaps
        for (int n = 0; n < 40; n++) begin
            logic [127:0] st;
            logic [31:0]  k;
            int j;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            st = {lfsr, ~lfsr, {lfsr[15:0], lfsr[31:16]}, lfsr ^ 32'hA5C3_0F96};
            k = lfsr * 32'd2654435761;
            j = n % 4;
            send(st, j, k, m_col(st, j, k), "R5 mixed data");
            if (n % 5 == 4) idle(n % 3 + 1);
        end
        idle(3);
        check(exp_q.size() == 0, "R9 all results seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule